// File: doc/BRIEF.md
# Two-Bit Cascadable ALU Slice

This block is a two-bit-wide slice of a processor datapath. Any number of copies placed side by side form a wider word. Each slice holds the following state:

- ten general scratch registers;
- a temporary register T;
- an accumulator AC;
- a memory address register MAR.

A seven-bit microfunction drives the slice on every clock. Its upper three bits pick the operation. Its lower four bits pick the operands and the destination.

The B operand always passes through the K mask before it reaches the adder or the logic. An all-ones mask therefore brings AC or the I bus into the operation, and an all-zeros mask removes it.

Slices are chained in two ways. The carry passes upward through the carry pins. The right shift passes downward from each slice's shift output to the next lower slice's shift input. Each slice also presents generate and propagate terms, so an external lookahead unit can replace the ripple carry. The data and address outputs are plain buses, each gated by an output enable.

Top module: `alu_slice`

## Requirements
- R1: After reset all scratch registers, T, AC and MAR hold zero, so the enabled data and address buses read all ones.
- R2: Microfunction bits [6:4] select the operation group and bits [3:0] select the register group.
  - Register codes 0 to 9 name scratch registers 0 to 9, code 10 names T and code 11 names AC (class I).
  - Codes 12 and 13 name AC and T with the M bus as operand (class II).
  - Codes 14 and 15 name AC and T with the I bus as operand (class III).
  - Each code reaches only its own register.
- R3: Group 0 class I writes Rn + (AC & K) + CI into both Rn and AC. Group 0 class II writes M + (AC & K) + CI into the selected AC or T. In both cases the adder carry drives CO.
- R4: Group 0 class III shifts the selected AC or T right by one bit. The old bit 0 appears on the shift output, the shift input fills the top bit, and CO stays inactive whatever CI is.
- R5: Group 1 loads MAR with K | A and writes A + K + CI into the destination. A is Rn in class I, M in class II, and the selected AC or T in class III.
- R6: Group 2 writes (X & K) plus all ones plus CI into the destination. X is AC in class I, M in class II and I in class III. The carry out of that sum drives CO.
- R7: Group 3 writes Rn + (AC & K) + CI into Rn only, M + (AC & K) + CI into AC or T, or T/AC + (I & K) + CI into AC or T, depending on the class.
- R8: Groups 4 to 7 compute A AND B, A OR B, A XNOR B and NOT A respectively, using the same A/B pairs as group 3. CO equals CI OR any bit of A & B, which gives a zero test across the chained slices.
- R9: An all-zeros K removes AC from group 0 class I, so the result is Rn + CI. An all-ones K passes AC through whole.
- R10: The I, K, M, D and address buses, CI and CO are active low at the ports.
- R11: For arithmetic, CO equals G | (P & CI). For logic, P is 1 and G is the OR of A & B. For a shift, both G and P are 0. Chained slices form a correct wider word.
- R12: MAR changes only in group 1. AC changes only when it is the destination or in group 0 class I.
- R13: With its enable low, the data bus or the address bus reads all ones, whatever the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fn | input | 7 | Microfunction: operation group and register group |
| m_n | input | W | Memory data bus, active low |
| i_n | input | W | Input-device bus, active low |
| k_n | input | W | Mask or literal bus, active low |
| ci_n | input | 1 | Carry in, active low |
| li | input | 1 | Shift-right input into the top bit |
| data_oe | input | 1 | Data bus enable |
| addr_oe | input | 1 | Address bus enable |
| d_n | output | W | AC contents, active low |
| addr_n | output | W | MAR contents, active low |
| co_n | output | 1 | Carry out, active low |
| ro | output | 1 | Shift-right output (old bit 0) |
| la_g | output | 1 | Lookahead generate term |
| la_p | output | 1 | Lookahead propagate term |

## Verification
The hardest behaviour to reach from the ports is the word-level behaviour that emerges only when several slices work together. Examples are a carry that ripples through every slice, a shift bit crossing each slice boundary, and a zero test that ORs across the chain. The bench wires four slices into an eight-bit word and applies operands that drive these paths: all-ones plus one with carry in, a shift with a set top input, and masked ANDs that leave zero. Scratch registers have no direct output, so their contents are brought out through a group 1 operation with K at zero, which copies the register to MAR and leaves it unchanged.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int NUM_SCRATCH = 10;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_T  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_AC = 4'd11;

  localparam logic [2:0] OP_SUM_AC = 3'd0;
  localparam logic [2:0] OP_ADDR   = 3'd1;
  localparam logic [2:0] OP_DECR   = 3'd2;
  localparam logic [2:0] OP_ACCUM  = 3'd3;
  localparam logic [2:0] OP_AND    = 3'd4;
  localparam logic [2:0] OP_OR     = 3'd5;
  localparam logic [2:0] OP_XNOR   = 3'd6;
  localparam logic [2:0] OP_INV    = 3'd7;

  typedef enum logic [1:0] {
    RC_REG = 2'd0,
    RC_MEM = 2'd1,
    RC_BUS = 2'd2
  } rclass_e;

  typedef struct packed {
    logic [2:0]       op;
    rclass_e          rclass;
    logic [IDX_W-1:0] idx;
    logic             also_ac;
    logic             mar_we;
    logic             shift;
  } ctrl_t;
endpackage

// File: rtl/slice_decode.sv
module slice_decode
  import alu_slice_pkg::*;
(
  input  logic [6:0] fn,
  output ctrl_t      ctl
);
  // R2: register field map
  always_comb begin
    ctl.op = fn[6:4];
    if (fn[3:0] < 4'd12) begin
      ctl.rclass = RC_REG;
      ctl.idx    = fn[3:0];
    end else begin
      ctl.rclass = fn[1] ? RC_BUS : RC_MEM;
      ctl.idx    = fn[0] ? IDX_T : IDX_AC;
    end
    ctl.also_ac = (ctl.op == OP_SUM_AC) && (ctl.rclass == RC_REG);
    ctl.mar_we  = (ctl.op == OP_ADDR);
    ctl.shift   = (ctl.op == OP_SUM_AC) && (ctl.rclass == RC_BUS);
  end
endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
  import alu_slice_pkg::*;
#(
  parameter int W    = 2,
  parameter int NREG = NUM_SCRATCH + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic             also_ac,
  input  logic             mar_we,
  input  logic [W-1:0]     mar_d,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     ac,
  output logic [W-1:0]     mar
);
  logic [W-1:0] regs [NREG];

  // every microfunction writes its selected register; group 0 class I also writes AC
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
      mar <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if ((int'(idx) == r) || (also_ac && (r == int'(IDX_AC))))
          regs[r] <= wdata;
      end
      if (mar_we) mar <= mar_d;
    end
  end

  assign rdata = regs[idx];
  assign ac    = regs[IDX_AC];
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_slice_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [2:0]   op,
  input  rclass_e      rclass,
  input  logic [W-1:0] rn,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] m,
  input  logic [W-1:0] ibus,
  input  logic [W-1:0] k,
  input  logic         ci,
  input  logic         li,
  output logic [W-1:0] res,
  output logic [W-1:0] mar_d,
  output logic         co,
  output logic         ro,
  output logic         la_g,
  output logic         la_p,
  output logic         is_arith,
  output logic         is_logic,
  output logic         is_shift
);
  function automatic logic [W:0] add_c(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  logic [W-1:0] a_op, b_op, kac, kin, and_t;
  logic [W:0]   sum_ci, sum_nc;

  always_comb begin
    kac = ac & k;
    kin = ibus & k;
    unique case (rclass)
      RC_REG:  begin a_op = rn; b_op = kac; end
      RC_MEM:  begin a_op = m;  b_op = kac; end
      default: begin a_op = rn; b_op = kin; end
    endcase
    if (op == OP_ADDR) b_op = k;
    if (op == OP_DECR) begin
      a_op = (rclass == RC_REG) ? kac : ((rclass == RC_MEM) ? (m & k) : kin);
      b_op = '1;
    end
  end

  assign sum_ci   = add_c(a_op, b_op, ci);
  assign sum_nc   = add_c(a_op, b_op, 1'b0);
  assign and_t    = a_op & b_op;
  assign is_shift = (op == OP_SUM_AC) && (rclass == RC_BUS);
  assign is_logic = op[2];
  assign is_arith = !op[2] && !is_shift;
  assign mar_d    = a_op | k;

  always_comb begin
    res  = sum_ci[W-1:0];
    co   = sum_ci[W];
    la_g = sum_nc[W];
    la_p = &(a_op ^ b_op);
    ro   = 1'b0;
    if (is_shift) begin
      res  = {li, rn[W-1:1]};
      ro   = rn[0];
      co   = 1'b0;
      la_g = 1'b0;
      la_p = 1'b0;
    end else if (is_logic) begin
      unique case (op[1:0])
        2'd0: res = a_op & b_op;
        2'd1: res = a_op | b_op;
        2'd2: res = ~(a_op ^ b_op);
        default: res = ~a_op;
      endcase
      co   = ci | (|and_t);
      la_g = |and_t;
      la_p = 1'b1;
    end
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [6:0]   fn,
  input  logic [W-1:0] m_n,
  input  logic [W-1:0] i_n,
  input  logic [W-1:0] k_n,
  input  logic         ci_n,
  input  logic         li,
  input  logic         data_oe,
  input  logic         addr_oe,
  output logic [W-1:0] d_n,
  output logic [W-1:0] addr_n,
  output logic         co_n,
  output logic         ro,
  output logic         la_g,
  output logic         la_p
);
  localparam int NREG = NUM_SCRATCH + 2;

  ctrl_t        ctl;
  logic [W-1:0] m, ibus, k, rn, ac, mar, res, mar_d;
  logic         ci, co, alu_arith, alu_logic, alu_shift;

  // R10: active-low boundary
  assign m    = ~m_n;
  assign ibus = ~i_n;
  assign k    = ~k_n;
  assign ci   = ~ci_n;

  slice_decode u_dec (.fn(fn), .ctl(ctl));

  slice_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(ctl.idx), .wdata(res), .also_ac(ctl.also_ac),
    .mar_we(ctl.mar_we), .mar_d(mar_d), .rdata(rn), .ac(ac), .mar(mar)
  );

  slice_alu #(.W(W)) u_alu (
    .op(ctl.op), .rclass(ctl.rclass), .rn(rn), .ac(ac), .m(m), .ibus(ibus), .k(k),
    .ci(ci), .li(li), .res(res), .mar_d(mar_d), .co(co), .ro(ro), .la_g(la_g),
    .la_p(la_p), .is_arith(alu_arith), .is_logic(alu_logic), .is_shift(alu_shift)
  );

  assign co_n   = ~co;
  assign d_n    = data_oe ? ~ac  : '1;
  assign addr_n = addr_oe ? ~mar : '1;

  AST_SHIFT_CO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shift && ci) |-> co_n);                                               // R4
  AST_LOGIC_CI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_logic && ci) |-> co);                                                 // R8
  AST_LOOKAHEAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    alu_arith |-> (co == (la_g | (la_p & ci))));                               // R11
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fn[6:4] != OP_ADDR) |=> $stable(mar));                                    // R12
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.also_ac && (ctl.idx != IDX_AC)) |=> $stable(ac));                    // R12
endmodule

// File: tb/alu_slice_bench.sv
`timescale 1ns/1ps
module alu_slice_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] fn = '0;
  logic [7:0] m_n = '1, i_n = '1, k_n = '1;
  logic       ci_n = 1'b1, li_w = 1'b0, doe = 1'b1, aoe = 1'b1;
  logic       nxt_doe = 1'b1, nxt_aoe = 1'b1;
  logic [7:0] d_n, addr_n;
  logic [4:0] cch, lch;
  logic [3:0] g_s, p_s;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  assign cch[0] = ci_n;
  assign lch[4] = li_w;

  for (genvar s = 0; s < 4; s++) begin : g_sl
    alu_slice #(.W(2)) u_alu_slice (
      .clk(clk), .rst_n(rst_n), .fn(fn), .m_n(m_n[2*s+:2]), .i_n(i_n[2*s+:2]),
      .k_n(k_n[2*s+:2]), .ci_n(cch[s]), .li(lch[s+1]), .data_oe(doe), .addr_oe(aoe),
      .d_n(d_n[2*s+:2]), .addr_n(addr_n[2*s+:2]), .co_n(cch[s+1]), .ro(lch[s]),
      .la_g(g_s[s]), .la_p(p_s[s])
    );
  end

  typedef struct {
    string      tag;
    logic [7:0] dn;
    logic [7:0] an;
  } exp_t;
  exp_t sb[$];

  logic [7:0] mr [12];
  logic [7:0] mmar;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: applies one microfunction, checks combinational outputs, queues registered results
  task automatic op(input logic [2:0] fg, input logic [3:0] rg, input logic [7:0] m,
                    input logic [7:0] i, input logic [7:0] k, input logic ci,
                    input logic li, input string tag);
    logic [7:0] a, b, res, kac, rn;
    logic [8:0] s9;
    logic       co, ro, c, mar_w, ac_w, arith, shift;
    int         tgt, cls;
    exp_t       it;
    cls   = (rg < 12) ? 1 : ((rg < 14) ? 2 : 3);
    tgt   = (rg < 12) ? int'(rg) : (rg[0] ? 10 : 11);
    rn    = mr[tgt];
    kac   = mr[11] & k;
    a     = (cls == 2) ? m : rn;
    b     = (cls == 3) ? (i & k) : kac;
    ro    = 1'b0; co = 1'b0; mar_w = 1'b0; ac_w = 1'b0; arith = 1'b1; shift = 1'b0;
    res   = '0;
    case (fg)
      3'd0: if (cls == 3) begin
              shift = 1'b1; arith = 1'b0;
              res = {li, rn[7:1]}; ro = rn[0];
            end else ac_w = (cls == 1);
      3'd1: begin b = k; mar_w = 1'b1; end
      3'd2: begin
              a = (cls == 1) ? kac : ((cls == 2) ? (m & k) : (i & k));
              b = 8'hFF;
            end
      3'd3: ;
      default: begin
        arith = 1'b0;
        case (fg)
          3'd4: res = a & b;
          3'd5: res = a | b;
          3'd6: res = ~(a ^ b);
          default: res = ~a;
        endcase
        co = ci | (|(a & b));
      end
    endcase
    if (arith) begin
      s9  = {1'b0, a} + {1'b0, b} + {8'd0, ci};
      res = s9[7:0];
      co  = s9[8];
    end
    @(negedge clk);
    fn = {fg, rg}; m_n = ~m; i_n = ~i; k_n = ~k; ci_n = ~ci; li_w = li;
    doe = nxt_doe; aoe = nxt_aoe;
    #1;
    chk({tag, " carry out"}, {7'd0, ~cch[4]}, {7'd0, co});
    if (shift) chk({tag, " shift out R4"}, {7'd0, lch[0]}, {7'd0, ro});
    c = ci;
    for (int s = 0; s < 4; s++) c = g_s[s] | (p_s[s] & c);
    chk({tag, " R11 lookahead vs ripple"}, {7'd0, c}, {7'd0, ~cch[4]});
    mr[tgt] = res;
    if (ac_w) mr[11] = res;
    if (mar_w) mmar = a | k;
    it.tag = tag;
    it.dn  = doe ? ~mr[11] : 8'hFF;
    it.an  = aoe ? ~mmar : 8'hFF;
    sb.push_back(it);
  endtask

  // monitor: compares registered outputs one step after each queued microfunction
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk({it.tag, " data bus"}, d_n, it.dn);
        chk({it.tag, " address bus R12"}, addr_n, it.an);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 12; r++) mr[r] = '0;
    mmar = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset data bus", d_n, 8'hFF);
    chk("R1 reset address bus", addr_n, 8'hFF);
    rst_n = 1'b1;
    op(3'd1, 4'd0,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R1 scratch 0 after reset");
    op(3'd1, 4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R1 AC after reset");
    // loads
    op(3'd0, 4'd12, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b0, "R3 load AC from M");
    op(3'd0, 4'd13, 8'h33, 8'h00, 8'h00, 1'b0, 1'b0, "R3 load T from M");
    op(3'd1, 4'd3,  8'h00, 8'h00, 8'h21, 1'b0, 1'b0, "R5 scratch 3 gets K");
    op(3'd0, 4'd3,  8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, "R9 all-ones mask adds AC");
    op(3'd1, 4'd3,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R3 read scratch 3");
    op(3'd0, 4'd5,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R9 all-zeros mask drops AC");
    op(3'd0, 4'd12, 8'hF0, 8'h00, 8'hFF, 1'b0, 1'b0, "R3 M plus AC");
    op(3'd0, 4'd12, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0, "R3 carry ripples all slices");
    // register map
    op(3'd1, 4'd9,  8'h00, 8'h00, 8'h44, 1'b0, 1'b0, "R2 write scratch 9");
    op(3'd1, 4'd0,  8'h00, 8'h00, 8'h11, 1'b0, 1'b0, "R2 write scratch 0");
    op(3'd1, 4'd9,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2 read scratch 9");
    op(3'd1, 4'd10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2 code 10 is T");
    op(3'd1, 4'd11, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2 code 11 is AC");
    op(3'd1, 4'd13, 8'h0C, 8'h00, 8'h81, 1'b1, 1'b0, "R5 class II M plus K");
    // decrement group
    op(3'd2, 4'd14, 8'h00, 8'h10, 8'hFF, 1'b0, 1'b0, "R6 I minus one");
    op(3'd2, 4'd14, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, "R6 masked I minus one no carry");
    op(3'd2, 4'd3,  8'h00, 8'h00, 8'h0F, 1'b1, 1'b0, "R6 class I masked AC");
    op(3'd1, 4'd3,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R6 read scratch 3");
    op(3'd2, 4'd13, 8'h46, 8'h00, 8'h0F, 1'b0, 1'b0, "R6 class II masked M");
    // accumulate group
    op(3'd3, 4'd15, 8'h00, 8'hC4, 8'h0F, 1'b1, 1'b0, "R7 T plus masked I");
    op(3'd1, 4'd15, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R7 read T");
    op(3'd3, 4'd12, 8'h01, 8'h00, 8'h80, 1'b0, 1'b0, "R7 M plus masked AC");
    op(3'd3, 4'd3,  8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, "R7 scratch only AC held");
    op(3'd1, 4'd3,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R7 read scratch 3");
    // shifts
    op(3'd0, 4'd14, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R4 shift AC fill one");
    op(3'd0, 4'd15, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R4 shift T fill zero");
    op(3'd1, 4'd15, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R4 read T");
    // logic group
    op(3'd4, 4'd14, 8'h00, 8'hF0, 8'h3C, 1'b0, 1'b0, "R8 AND zero test");
    op(3'd5, 4'd14, 8'h00, 8'hAA, 8'h0F, 1'b0, 1'b0, "R8 OR");
    op(3'd6, 4'd12, 8'h0F, 8'h00, 8'hFF, 1'b0, 1'b0, "R8 XNOR nonzero test");
    op(3'd7, 4'd11, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R8 NOT passes carry in");
    op(3'd4, 4'd3,  8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, "R8 AND scratch with AC");
    // enables and active-low polarity
    nxt_doe = 1'b0;
    op(3'd3, 4'd12, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0, "R13 data bus disabled");
    nxt_doe = 1'b1; nxt_aoe = 1'b0;
    op(3'd1, 4'd12, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, "R13 address bus disabled");
    nxt_aoe = 1'b1;
    op(3'd0, 4'd12, 8'h96, 8'h00, 8'h00, 1'b0, 1'b0, "R10 data bus inverted");
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule